// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block performs the arithmetic and logic step of a data-processing instruction. A 4-bit operation code picks one of sixteen operations on a first operand `a` and a second operand `b`. The second operand arrives already shifted, together with the carry bit the shifter produced. The result comes out combinationally, along with a write-enable for the destination register.

The four condition flags (negative, zero, carry, overflow) live in a register inside the block. They change on the clock edge that ends an operation, and only when the operation asks for a flag update. The current carry feeds the carry-using operations, so a chain of add-with-carry or subtract-with-carry operations works across cycles.

When flags are requested and the destination is register 15 for an operation that writes a result, the block raises `restore` in place of the normal flag update. The surrounding pipeline uses that strobe to restore the processor mode.

Top module: `dp_alu`

## Requirements
- R1: Logic codes produce these results: 0 `a&b`, 1 `a^b`, 8 `a&b`, 9 `a^b`, 12 `a|b`, 13 `b`, 14 `a&~b`, 15 `~b`.
- R2: Arithmetic codes produce these results, modulo 2^W, with C the current carry flag: 2 `a-b`, 3 `b-a`, 4 `a+b`, 5 `a+b+C`, 6 `a-b-1+C`, 7 `b-a-1+C`, 10 `a-b`, 11 `a+b`.
- R3: `wr_en` is low for codes 8 to 11 and high for all other codes.
- R4: While `set_flags` is low, `flags` keeps its value across the clock edge.
- R5: For logic codes with a flag update, N is result bit W-1, Z is set when the result is zero, C takes `shift_c`, and V is unchanged.
- R6: Codes 2, 6 and 10 set the flags of `a + ~b + cin`. cin is 1 for codes 2 and 10 and the current C for code 6. C is the carry-out (no borrow) and V is the signed overflow.
- R7: Codes 3 and 7 set the flags of `b + ~a + cin`. cin is 1 for code 3 and the current C for code 7.
- R8: Codes 4, 11 and 5 set the flags of `a + b + cin`. cin is 0 for codes 4 and 11 and the current C for code 5. C is the carry-out of bit W-1 and V is set when both operands share a sign that differs from the sign of the result.
- R9: `restore` is high exactly when `set_flags` is high, `dest` is 15 and the code writes a result. While `restore` is high, `flags` keeps its value.
- R10: After reset, `flags` is zero. Its packing is {N,Z,C,V}, with N in bit 3 and V in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 4 | Operation code |
| a | input | W | First operand |
| b | input | W | Shifted second operand |
| shift_c | input | 1 | Carry-out of the shifter |
| set_flags | input | 1 | Request a flag update |
| dest | input | 4 | Destination register index |
| result | output | W | Operation result |
| wr_en | output | 1 | Destination write-enable |
| restore | output | 1 | Mode-restore strobe |
| flags | output | 4 | Registered {N,Z,C,V} |

## Verification
The carry-using codes depend on a carry flag that only earlier operations can set, so their inputs cannot be set from the ports alone. The bench runs every operand pair of a 4-bit instance through every code with the flag update both on and off. It keeps its own running copy of the flags, so each carry-using operation sees whatever carry the previous vector left behind. Both carry values therefore turn up many times for codes 5, 6 and 7. The destination index is derived from the operands, so register 15 coincides with writing and non-writing codes alike.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         shift_c,
  input  logic         set_flags,
  input  logic [3:0]   dest,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         restore,
  output logic [3:0]   flags
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y, y_eff, logic_res;
  logic [W:0]   sum;
  logic         cin, is_arith, is_sub, c_new, v_new;
  logic [3:0]   flags_d;

  assign is_sub   = op inside {4'h2, 4'h3, 4'h6, 4'h7, 4'hA};
  assign is_arith = is_sub || op inside {4'h4, 4'h5, 4'hB};

  always_comb begin
    x = a;
    y = b;
    if (op == 4'h3 || op == 4'h7) begin
      x = b;
      y = a;
    end
  end

  always_comb begin
    case (op)
      4'h2, 4'h3, 4'hA: cin = 1'b1;
      4'h5, 4'h6, 4'h7: cin = flags[1];
      default:          cin = 1'b0;
    endcase
  end

  assign y_eff = is_sub ? ~y : y;
  assign sum   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};

  always_comb begin
    case (op)
      4'h0, 4'h8: logic_res = a & b;
      4'h1, 4'h9: logic_res = a ^ b;
      4'hC:       logic_res = a | b;
      4'hD:       logic_res = b;
      4'hE:       logic_res = a & ~b;
      default:    logic_res = ~b;
    endcase
  end

  assign result  = is_arith ? sum[W-1:0] : logic_res;
  assign wr_en   = op[3:2] != 2'b10;
  assign restore = set_flags && wr_en && dest == 4'd15;

  assign c_new = is_arith ? sum[W] : shift_c;
  assign v_new = is_arith ? (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]) : flags[0];
  assign flags_d = {result[MSB], result == '0, c_new, v_new};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flags <= 4'b0000;
    else if (set_flags && !restore) flags <= flags_d;
  end
endmodule

module dp_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic         shift_c,
  input logic         set_flags,
  input logic [3:0]   dest,
  input logic [W-1:0] result,
  input logic         wr_en,
  input logic         restore,
  input logic [3:0]   flags
);
  a_r3_no_write_on_test: assert property (@(posedge clk) disable iff (!rst_n)
    (op[3:2] == 2'b10) |-> !wr_en);

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> $stable(flags));

  a_r9_restore_hold: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> $stable(flags));

  a_r9_restore_cause: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> (set_flags && dest == 4'd15 && wr_en));

  a_r5_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !restore && (op inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF}))
    |=> (flags[1] == $past(shift_c)) && (flags[0] == $past(flags[0])));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !restore) |=> (flags[2] == ($past(result) == '0)));
endmodule

bind dp_alu dp_alu_chk #(.W(W)) i_dp_alu_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .shift_c(shift_c), .set_flags(set_flags),
  .dest(dest), .result(result), .wr_en(wr_en), .restore(restore), .flags(flags)
);

// File: tb/test_dp_alu.sv
module test_dp_alu;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic         shift_c = 1'b0, set_flags = 1'b0;
  logic [3:0]   dest = '0;
  logic [W-1:0] result;
  logic         wr_en, restore;
  logic [3:0]   flags;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dp_alu #(.W(W)) i_dp_alu (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .shift_c(shift_c),
    .set_flags(set_flags), .dest(dest), .result(result), .wr_en(wr_en),
    .restore(restore), .flags(flags)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s op=%0h a=%0d b=%0d actual=%0h expected=%0h", tag, op, a, b, act, exp);
    end
  endtask

  function automatic int sgn(input int v);
    return (v >= HALF) ? v - (1 << W) : v;
  endfunction

  function automatic bit ovf(input int s);
    return (s < -HALF) || (s > HALF - 1);
  endfunction

  int cur;

  initial begin
    #(20 * 60000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #35;
    check(flags == 4'b0000, "R10", flags, 0);
    rst_n = 1'b1;
    cur = 0;
    @(negedge clk);
    for (int o = 0; o < 16; o++)
      for (int x = 0; x <= M; x++)
        for (int y = 0; y <= M; y++)
          for (int k = 0; k < 4; k++) begin
            int r, cc, vv, c, nf;
            bit logical, wr, rs, s;
            string rtag, ftag;
            s = k[0];
            op = 4'(o); a = W'(x); b = W'(y);
            shift_c = k[1] ^ x[0];
            set_flags = s;
            dest = 4'((x * 3 + y + o + k) & 15);
            c = (cur >> 1) & 1;
            logical = 0;
            vv = cur & 1;
            cc = 0;
            rtag = "R2";
            case (o)
              2, 10: begin r = (x - y) & M; cc = x >= y; vv = ovf(sgn(x) - sgn(y)); ftag = "R6"; end
              6: begin r = (x - y - 1 + c) & M; cc = x >= y + 1 - c; vv = ovf(sgn(x) - sgn(y) - 1 + c); ftag = "R6"; end
              3: begin r = (y - x) & M; cc = y >= x; vv = ovf(sgn(y) - sgn(x)); ftag = "R7"; end
              7: begin r = (y - x - 1 + c) & M; cc = y >= x + 1 - c; vv = ovf(sgn(y) - sgn(x) - 1 + c); ftag = "R7"; end
              4, 11: begin r = (x + y) & M; cc = (x + y) > M; vv = ovf(sgn(x) + sgn(y)); ftag = "R8"; end
              5: begin r = (x + y + c) & M; cc = (x + y + c) > M; vv = ovf(sgn(x) + sgn(y) + c); ftag = "R8"; end
              default: begin
                logical = 1;
                rtag = "R1";
                ftag = "R5";
                case (o)
                  0, 8: r = x & y;
                  1, 9: r = x ^ y;
                  12: r = x | y;
                  13: r = y;
                  14: r = x & (~y & M);
                  default: r = ~y & M;
                endcase
              end
            endcase
            if (logical) cc = shift_c;
            wr = !(o >= 8 && o <= 11);
            rs = s && wr && (dest == 15);
            if (s && !rs) nf = ((r >> (W - 1)) << 3) | ((r == 0) << 2) | (cc << 1) | vv;
            else nf = cur;
            if (!s) ftag = "R4";
            else if (rs) ftag = "R9";
            #5;
            check(result == W'(r), rtag, result, r);
            check(wr_en == wr, "R3", wr_en, wr);
            check(restore == rs, "R9", restore, rs);
            @(negedge clk);
            check(flags == 4'(nf), ftag, flags, nf);
            cur = nf;
          end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule